// File: doc/BRIEF.md
# Table-Select Reconfigurable Ripple ALU

This block is a small arithmetic and logic unit built from identical one-bit slices. Each slice holds no adder, gate array or multiplier. Instead, three four-way selectors act as the neurons of a tiny two-layer perceptron. Two hidden selectors are indexed by the operand bit pair. The output selector is indexed by the pair of hidden outputs. The opcode sets the four entries of each selector. An entry is a constant, the incoming carry or borrow, or its inverse.

Seven two-input logic functions use all three selectors. For add and subtract, the hidden selectors are given entries that depend on the carry or borrow. Neuron one then yields the sum or difference bit, and neuron two yields the carry or borrow. The output selector is bypassed. A parameterised wrapper chains the slices into a ripple ALU, 8 bits wide by default. The wrapper captures the result and the final carry or borrow in an output register that has a clock enable.

Top module: `selalu_top`

## Requirements
- R1: While `rst_n` is low and at the first clock edge after reset, `result` and `cout` are 0.
- R2: On a rising clock edge with `en` high, the outputs take the value computed from `op`, `a`, `b` and `cin` before that edge. With `en` low they keep their value.
- R3: Opcodes 0 to 6 select bitwise logic on `a` and `b`: 0 AND, 1 OR, 2 NAND, 3 NOR, 5 XOR and 6 XNOR. Each bit follows that gate's truth table.
- R4: Opcode 4 gives the bitwise inverse of `a`. Neither `b` nor `cin` affects the result.
- R5: Opcode 7 adds. `{cout, result}` equals `a + b + cin` as unsigned values of W+1 bits.
- R6: Opcode 8 subtracts. `result` equals `(a - b - cin)` modulo 2^W, and `cout` is 1 exactly when `a < b + cin`.
- R7: The carry or borrow ripples from bit 0 to bit W-1. Bit 0 takes `cin` and bit W-1 drives `cout`. A carry or borrow generated at bit 0 reaches the top bit, for example 0xFF + 1 and 0 - 1.
- R8: For opcodes 0 to 6, `cout` is 0 whatever `cin` is.
- R9: Opcodes 9 to 15 give `result` = 0 and `cout` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output register clock enable |
| op | input | 4 | Operation code |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry-in (add) or borrow-in (subtract) into bit 0 |
| result | output | W | Registered result |
| cout | output | 1 | Registered carry-out or borrow-out of the top bit |

## Verification
The slice array is purely combinational, so every result is due at the first enabled rising edge after its operands are applied. The outputs therefore show it one cycle after the stimulus. The bench drives inputs on a falling edge and predicts the outputs from a behavioural model using integer arithmetic and bitwise operators. It compares them on the next falling edge, after exactly one rising edge has passed. When the enable is low, the model keeps its previous prediction, so a hold is checked in the same cycle position as an update.

// File: rtl/selalu_pkg.sv
package selalu_pkg;

  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_AND  = 4'd0;
  localparam logic [OPW-1:0] OP_OR   = 4'd1;
  localparam logic [OPW-1:0] OP_NAND = 4'd2;
  localparam logic [OPW-1:0] OP_NOR  = 4'd3;
  localparam logic [OPW-1:0] OP_NOTA = 4'd4;
  localparam logic [OPW-1:0] OP_XOR  = 4'd5;
  localparam logic [OPW-1:0] OP_XNOR = 4'd6;
  localparam logic [OPW-1:0] OP_ADD  = 4'd7;
  localparam logic [OPW-1:0] OP_SUB  = 4'd8;

  // Entry vectors: bit k is the entry picked by index k, index = {hi, lo}.
  typedef struct packed {
    logic [3:0] hid1;   // neuron one entries, indexed by {a, b}
    logic [3:0] hid2;   // neuron two entries, indexed by {a, b}
    logic [3:0] outn;   // output neuron entries, indexed by {f1, f2}
    logic       arith;  // bypass output neuron
  } entry_set_t;

endpackage

// File: rtl/selalu_entry_gen.sv
module selalu_entry_gen
  import selalu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           cin,
  output entry_set_t     ent
);

  // Pass-through hidden layer for logic: f1 follows a, f2 follows b.
  localparam logic [3:0] HID_A = 4'b1100;
  localparam logic [3:0] HID_B = 4'b1010;

  always_comb begin
    ent.hid1  = HID_A;
    ent.hid2  = HID_B;
    ent.outn  = 4'b0000;
    ent.arith = 1'b0;
    case (op)
      OP_AND:  ent.outn = 4'b1000;
      OP_OR:   ent.outn = 4'b1110;
      OP_NAND: ent.outn = 4'b0111;
      OP_NOR:  ent.outn = 4'b0001;
      OP_NOTA: ent.outn = 4'b0011;
      OP_XOR:  ent.outn = 4'b0110;
      OP_XNOR: ent.outn = 4'b1001;
      OP_ADD: begin
        ent.arith = 1'b1;
        ent.hid1  = {cin, ~cin, ~cin, cin};
        ent.hid2  = {1'b1, cin, cin, 1'b0};
      end
      OP_SUB: begin
        ent.arith = 1'b1;
        ent.hid1  = {cin, ~cin, ~cin, cin};
        ent.hid2  = {cin, 1'b0, 1'b1, cin};
      end
      default: begin
        ent.hid1 = 4'b0000;
        ent.hid2 = 4'b0000;
      end
    endcase
  end

endmodule

// File: rtl/selalu_pick4.sv
module selalu_pick4 (
  input  logic [3:0] entries,
  input  logic [1:0] sel,
  output logic       y
);

  always_comb begin
    case (sel)
      2'd0:    y = entries[0];
      2'd1:    y = entries[1];
      2'd2:    y = entries[2];
      default: y = entries[3];
    endcase
  end

endmodule

// File: rtl/selalu_slice.sv
module selalu_slice
  import selalu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           a,
  input  logic           b,
  input  logic           cin,
  output logic           y,
  output logic           cout
);

  entry_set_t ent;
  logic f1, f2, g;

  selalu_entry_gen u_gen (.op(op), .cin(cin), .ent(ent));

  selalu_pick4 u_n1 (.entries(ent.hid1), .sel({a, b}),   .y(f1));
  selalu_pick4 u_n2 (.entries(ent.hid2), .sel({a, b}),   .y(f2));
  selalu_pick4 u_n3 (.entries(ent.outn), .sel({f1, f2}), .y(g));

  assign y    = ent.arith ? f1 : g;
  assign cout = ent.arith ? f2 : 1'b0;

endmodule

// File: rtl/selalu_top.sv
module selalu_top
  import selalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [3:0]     op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   result,
  output logic           cout
);

  localparam int SUMW = W + 1;

  logic [W:0]   chain;
  logic [W-1:0] res_c;
  logic [W-1:0] res_d;
  logic         cout_d;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    selalu_slice u_slice (
      .op   (op),
      .a    (a[i]),
      .b    (b[i]),
      .cin  (chain[i]),
      .y    (res_c[i]),
      .cout (chain[i+1])
    );
  end

  // Next-state: hold unless enabled.
  always_comb begin
    res_d  = result;
    cout_d = cout;
    if (en) begin
      res_d  = res_c;
      cout_d = chain[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      cout   <= 1'b0;
    end else begin
      result <= res_d;
      cout   <= cout_d;
    end
  end

  // R5 addition against arithmetic
  a_r5_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_ADD) |=>
      {cout, result} == ({1'b0, $past(a)} + {1'b0, $past(b)} + SUMW'($past(cin))));

  // R6 subtraction against arithmetic
  a_r6_sub_diff: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_SUB) |=>
      {cout, result} == ({1'b0, $past(a)} - {1'b0, $past(b)} - SUMW'($past(cin))));

  // R8 no carry for logic codes
  a_r8_logic_nocarry: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= OP_XNOR) |=> !cout);

  // R9 unused codes give zero
  a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op > OP_SUB) |=> (result == '0 && !cout));

  // R2 hold while disabled
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(cout)));

  // R4 inverse of a
  a_r4_nota: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_NOTA) |=> result == ~$past(a));

endmodule

// File: tb/selalu_top_bench.sv
`timescale 1ns/1ps
module selalu_top_bench;

  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [3:0]   op;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] result;
  logic         cout;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int exp_res  = 0;
  int exp_c    = 0;

  always #2.5 clk = ~clk;

  selalu_top #(.W(W)) u_selalu_top (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .a(a), .b(b),
    .cin(cin), .result(result), .cout(cout)
  );

  task automatic check(input string tag);
    n_checks++;
    if (int'(result) != exp_res || int'(cout) != exp_c) begin
      n_fail++;
      $display("FAIL %s: op=%0d got res=%0h c=%0d expected res=%0h c=%0d",
               tag, op, result, cout, exp_res, exp_c);
    end
  endtask

  function automatic void model(input int o, input int x, input int y, input int ci);
    int t;
    exp_c = 0;
    case (o)
      0: exp_res = x & y;
      1: exp_res = x | y;
      2: exp_res = ~(x & y) & MASK;
      3: exp_res = ~(x | y) & MASK;
      4: exp_res = ~x & MASK;
      5: exp_res = x ^ y;
      6: exp_res = ~(x ^ y) & MASK;
      7: begin t = x + y + ci; exp_res = t & MASK; exp_c = (t >> W) & 1; end
      8: begin t = x - y - ci; exp_res = t & MASK; exp_c = (t < 0) ? 1 : 0; end
      default: exp_res = 0;
    endcase
  endfunction

  task automatic run(input string tag, input int o, input int x, input int y,
                     input int ci, input bit e);
    @(negedge clk);
    op = 4'(o); a = W'(x); b = W'(y); cin = ci[0]; en = e;
    if (e) model(o, x, y, ci);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; op = '0; a = '0; b = '0; cin = 1'b0;
    repeat (3) @(negedge clk);
    exp_res = 0; exp_c = 0;
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first edge");

    // R3 R8 bit pair coverage and cin insensitivity
    for (int o = 0; o < 7; o++) begin
      run("R3 R8 pairs", o, 8'hCC, 8'hAA, 1, 1'b1);
      run("R3 R8 pairs", o, 8'h0F, 8'h35, 0, 1'b1);
      for (int k = 0; k < 40; k++)
        run("R3 random", o, $urandom & MASK, $urandom & MASK, $urandom & 1, 1'b1);
    end
    // R4 b and cin have no effect
    run("R4 nota", 4, 8'h5A, 8'h00, 0, 1'b1);
    run("R4 nota", 4, 8'h5A, 8'hFF, 1, 1'b1);

    // R5 R7 addition
    run("R5 R7 ff+1", 7, 8'hFF, 8'h01, 0, 1'b1);
    run("R5 R7 ff+ff+1", 7, 8'hFF, 8'hFF, 1, 1'b1);
    run("R5 R7 ff+0+cin", 7, 8'hFF, 8'h00, 1, 1'b1);
    run("R5 zero", 7, 0, 0, 0, 1'b1);
    for (int k = 0; k < 200; k++)
      run("R5 random", 7, $urandom & MASK, $urandom & MASK, $urandom & 1, 1'b1);

    // R6 R7 subtraction
    run("R6 R7 0-1", 8, 0, 1, 0, 1'b1);
    run("R6 R7 0-0-bin", 8, 0, 0, 1, 1'b1);
    run("R6 equal", 8, 8'h80, 8'h80, 0, 1'b1);
    run("R6 ff-ff-bin", 8, 8'hFF, 8'hFF, 1, 1'b1);
    for (int k = 0; k < 200; k++)
      run("R6 random", 8, $urandom & MASK, $urandom & MASK, $urandom & 1, 1'b1);

    // R9 unused codes
    for (int o = 9; o < 16; o++)
      run("R9 unused", o, 8'hFF, 8'hFF, 1, 1'b1);

    // R2 hold while disabled
    run("R2 load", 7, 8'hFF, 8'hFF, 1, 1'b1);
    run("R2 hold", 0, 8'h00, 8'h00, 0, 1'b0);
    run("R2 hold", 9, 8'h12, 8'h34, 0, 1'b0);
    run("R2 update", 1, 8'h12, 8'h34, 0, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: expected completion, got timeout");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule